// File: doc/BRIEF.md
# Interrupt Recognition Unit

This block sits beside a processor's execution unit and decides, each time an instruction finishes, whether the core must branch to an interrupt handler and which vector type the handler uses. It has two request sources. The first is an unmaskable line that acts on its rising edge and always supplies a fixed vector type. The second is a maskable line that is read as a level, and only at the instruction boundary. When the maskable request wins, the block asks the bus unit to run an acknowledge cycle. The vector type is then taken from the byte that comes back on the data bus.

The execution unit raises `instrEnd` during the last clock of every instruction. The block answers with a one-cycle `takeInt` strobe and a registered `vecType`. The block also synchronizes the wait-for-test input. The core uses `testHold` to decide whether a waiting instruction may proceed. Vector table fetch, stacking and handler execution belong to other blocks.

Top module: `irq_recog_top`

## Requirements
- R1: After reset (`rstN` low), `takeInt`=0, `ackReq`=0 and `vecType`=0x00. `testHold`=1. No unmaskable request is pending.
- R2: A rising edge on `nmiAsync` is taken at the next `instrEnd`, whatever the value of `ifFlag`. `takeInt` is 1 in the cycle after the `instrEnd` cycle, with `vecType`=0x02 and `ackReq` staying 0.
- R3: Holding `nmiAsync` high produces only one take. A later boundary with the line still high produces no `takeInt`.
- R4: A detected unmaskable edge stays pending across any number of cycles without `instrEnd`. It is cleared by its take, so the boundary after the take produces no `takeInt`.
- R5: The maskable request is accepted only when `intrLvl`=1 and `ifFlag`=1 in the `instrEnd` cycle. Any other combination leaves `ackReq` and `takeInt` at 0.
- R6: For an accepted maskable request, `ackReq` goes to 1 from the cycle after the boundary and stays there until `ackValid` is sampled high. `takeInt`=1 follows one cycle later, with `vecType` equal to the `ackData` byte sampled with `ackValid`.
- R7: When both sources are pending at one boundary, the unmaskable one is taken (type 0x02, no `ackReq`). The maskable line is evaluated again at the following boundary.
- R8: `intrLvl` is not looked at outside `instrEnd` cycles. A pulse between boundaries that is gone by the boundary causes nothing.
- R9: `testHold` follows `testIn` after exactly two rising clock edges. A value of 1 means a waiting core stays idle; 0 means it continues.
- R10: `instrEnd` pulses during an acknowledge cycle are ignored. An unmaskable edge that arrives during an acknowledge cycle stays pending and is taken at the next boundary after the acknowledge completes.
- R11: `vecType` keeps its value between takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| nmiAsync | input | 1 | Unmaskable request, asynchronous, edge-sensitive |
| intrLvl | input | 1 | Maskable request level |
| ifFlag | input | 1 | Interrupt-enable flag from the core |
| instrEnd | input | 1 | High in the last clock of each instruction |
| ackValid | input | 1 | Type byte valid on ackData during the acknowledge cycle |
| ackData | input | 8 | Vector type returned on the data bus |
| testIn | input | 1 | Asynchronous wait-for-test input |
| ackReq | output | 1 | Request to run an acknowledge bus cycle |
| takeInt | output | 1 | One-cycle strobe: take the interrupt now |
| vecType | output | 8 | Vector type of the last take |
| testHold | output | 1 | Synchronized test input, 1 = keep waiting |

## Verification
The bench sends both sources to the same boundary. A design that put the maskable source first would raise `ackReq` and return the bus byte instead of type 2. It holds the unmaskable line high across two boundaries, which catches a level-triggered design that would take the same request again. It leaves an edge pending for many cycles and puts one inside an acknowledge cycle: a design that dropped the pending flag, or cleared it when the acknowledge finished, would lose that request. It also pulses the maskable line between boundaries and counts synchronizer edges on the test input, so a design that sampled `intrLvl` outside `instrEnd` or used the wrong number of stages would be caught.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } irq_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeNmi;   // load fixed unmaskable vector type
    logic takeIntr;  // load vector type from bus byte
    logic nmiClr;    // drop the pending unmaskable request
  } irq_strobe_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[LAST-1:0], din};
      end
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int             VEC_W      = 8,
  parameter int             SYNC_STG   = 2,
  parameter logic [VEC_W-1:0] NMI_VEC  = 8'd2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiAsync,
  input  logic             testIn,
  input  logic [VEC_W-1:0] ackData,
  input  irq_strobe_t      strb,
  output logic             nmiPend,
  output logic [VEC_W-1:0] vecType,
  output logic             testHold
);
  logic nmiSync;
  logic nmiPrev;
  logic nmiRise;

  irq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_nmiSync (
    .clk(clk), .rstN(rstN), .din(nmiAsync), .dout(nmiSync)
  );

  irq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_testSync (
    .clk(clk), .rstN(rstN), .din(testIn), .dout(testHold)
  );

  assign nmiRise = nmiSync & ~nmiPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiSync;
      // a fresh edge wins over a clear in the same cycle
      nmiPend <= nmiRise | (nmiPend & ~strb.nmiClr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              vecType <= '0;
    else if (strb.takeNmi)  vecType <= NMI_VEC;
    else if (strb.takeIntr) vecType <= ackData;
  end

  // R4: pending request survives until cleared
  a_r4_pend_hold: assert property (@(posedge clk) disable iff (!rstN)
    nmiPend && !strb.nmiClr |=> nmiPend);

  // R2: unmaskable take loads the fixed type
  a_r2_nmi_vector: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeNmi |=> vecType == NMI_VEC);

  // R11: vector holds without a take
  a_r11_vec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.takeNmi || strb.takeIntr) |=> $stable(vecType));

  // R7: never two sources in one cycle
  a_r7_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeNmi, strb.takeIntr}));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrEnd,
  input  logic        intrLvl,
  input  logic        ifFlag,
  input  logic        ackValid,
  input  logic        nmiPend,
  output irq_strobe_t strb,
  output logic        ackReq,
  output logic        takeInt
);
  irq_state_t state;
  irq_state_t stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (instrEnd) begin
          if (nmiPend) begin
            strb.takeNmi = 1'b1;
            strb.nmiClr  = 1'b1;
          end else if (intrLvl && ifFlag) begin
            stateNext = ST_ACK;
          end
        end
      end
      ST_ACK: begin
        if (ackValid) begin
          strb.takeIntr = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      takeInt <= 1'b0;
    end else begin
      state   <= stateNext;
      takeInt <= strb.takeNmi | strb.takeIntr;
    end
  end

  assign ackReq = (state == ST_ACK);

  // R6: acknowledge request held until the type byte arrives
  a_r6_ack_hold: assert property (@(posedge clk) disable iff (!rstN)
    ackReq && !ackValid |=> ackReq);

  // R6: completed acknowledge yields a take
  a_r6_ack_take: assert property (@(posedge clk) disable iff (!rstN)
    ackReq && ackValid |=> takeInt && !ackReq);

  // R7: unmaskable source has priority at a boundary
  a_r7_nmi_first: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq && instrEnd && nmiPend |=> takeInt && !ackReq);

  // R5: masked or absent request does nothing
  a_r5_masked: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq && instrEnd && !nmiPend && !(intrLvl && ifFlag) |=> !takeInt && !ackReq);
endmodule

// File: rtl/irq_recog_top.sv
module irq_recog_top
  import irq_pkg::*;
#(
  parameter int               VEC_W    = 8,
  parameter int               SYNC_STG = 2,
  parameter logic [VEC_W-1:0] NMI_VEC  = 8'd2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiAsync,
  input  logic             intrLvl,
  input  logic             ifFlag,
  input  logic             instrEnd,
  input  logic             ackValid,
  input  logic [VEC_W-1:0] ackData,
  input  logic             testIn,
  output logic             ackReq,
  output logic             takeInt,
  output logic [VEC_W-1:0] vecType,
  output logic             testHold
);
  irq_strobe_t strb;
  logic        nmiPend;

  irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrEnd(instrEnd), .intrLvl(intrLvl),
    .ifFlag(ifFlag), .ackValid(ackValid), .nmiPend(nmiPend),
    .strb(strb), .ackReq(ackReq), .takeInt(takeInt)
  );

  irq_datapath #(.VEC_W(VEC_W), .SYNC_STG(SYNC_STG), .NMI_VEC(NMI_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .nmiAsync(nmiAsync), .testIn(testIn),
    .ackData(ackData), .strb(strb), .nmiPend(nmiPend),
    .vecType(vecType), .testHold(testHold)
  );
endmodule

// File: tb/irq_recog_top_tb.sv
module irq_recog_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nmiAsync = 1'b0, intrLvl = 1'b0, ifFlag = 1'b0, instrEnd = 1'b0;
  logic       ackValid = 1'b0, testIn = 1'b1;
  logic [7:0] ackData = 8'h00;
  logic       ackReq, takeInt, testHold;
  logic [7:0] vecType;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_recog_top u_dut (
    .clk(clk), .rstN(rstN), .nmiAsync(nmiAsync), .intrLvl(intrLvl),
    .ifFlag(ifFlag), .instrEnd(instrEnd), .ackValid(ackValid),
    .ackData(ackData), .testIn(testIn), .ackReq(ackReq),
    .takeInt(takeInt), .vecType(vecType), .testHold(testHold)
  );

  // fields: intr, if, ack byte, expect accept
  localparam logic [10:0] TBL [6] = '{
    {1'b1, 1'b1, 8'h21, 1'b1},
    {1'b1, 1'b0, 8'h33, 1'b0},
    {1'b0, 1'b1, 8'h44, 1'b0},
    {1'b0, 1'b0, 8'h55, 1'b0},
    {1'b1, 1'b1, 8'hFF, 1'b1},
    {1'b1, 1'b1, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle instruction boundary; returns at the negedge where results show
  task automatic boundary(input logic intr, input logic ifl);
    intrLvl = intr; ifFlag = ifl; instrEnd = 1'b1;
    @(negedge clk);
    instrEnd = 1'b0;
  endtask

  task automatic ackCycle(input logic [7:0] b);
    ackValid = 1'b1; ackData = b;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic nmiPulse();
    nmiAsync = 1'b1; cyc(1); nmiAsync = 1'b0; cyc(4);
  endtask

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 takeInt", takeInt, 0);
    chk("R1 ackReq", ackReq, 0);
    chk("R1 vecType", vecType, 0);
    chk("R1 testHold", testHold, 1);
    rstN = 1'b1;
    cyc(2);
    boundary(1'b0, 1'b1);
    chk("R1 no pending take", takeInt, 0);

    // R5 R6 table of maskable cases
    for (int k = 0; k < 6; k++) begin
      boundary(TBL[k][10], TBL[k][9]);
      intrLvl = 1'b0;
      chk("R5 ackReq", ackReq, TBL[k][0]);
      chk("R5 takeInt", takeInt, 0);
      if (TBL[k][0]) begin
        cyc(2);
        chk("R6 ackReq held", ackReq, 1);
        ackCycle(TBL[k][8:1]);
        chk("R6 takeInt", takeInt, 1);
        chk("R6 vecType", vecType, TBL[k][8:1]);
        chk("R6 ackReq drop", ackReq, 0);
        cyc(1);
        chk("R6 strobe one cycle", takeInt, 0);
      end
      cyc(1);
    end

    // R2 unmaskable edge with flag clear
    nmiAsync = 1'b1; cyc(4);
    boundary(1'b0, 1'b0);
    chk("R2 takeInt", takeInt, 1);
    chk("R2 vecType", vecType, 2);
    chk("R2 ackReq", ackReq, 0);
    cyc(1);
    chk("R2 strobe one cycle", takeInt, 0);
    // R3 level held high: no second take
    boundary(1'b0, 1'b0);
    chk("R3 no retake", takeInt, 0);
    nmiAsync = 1'b0; cyc(4);

    // R4 pending held across many cycles, cleared by take
    nmiPulse(); cyc(20);
    boundary(1'b0, 1'b1);
    chk("R4 late take", takeInt, 1);
    chk("R4 vecType", vecType, 2);
    cyc(1);
    boundary(1'b0, 1'b1);
    chk("R4 cleared", takeInt, 0);

    // R7 both pending: unmaskable first, then maskable
    nmiPulse();
    boundary(1'b1, 1'b1);
    chk("R7 take first", takeInt, 1);
    chk("R7 vec 2", vecType, 2);
    chk("R7 no ack", ackReq, 0);
    cyc(1);
    boundary(1'b1, 1'b1);
    intrLvl = 1'b0;
    chk("R7 ack next boundary", ackReq, 1);
    ackCycle(8'h45);
    chk("R7 maskable vec", vecType, 8'h45);
    cyc(1);

    // R8 pulse between boundaries ignored
    ifFlag = 1'b1; intrLvl = 1'b1; cyc(2); intrLvl = 1'b0; cyc(1);
    boundary(1'b0, 1'b1);
    chk("R8 ackReq", ackReq, 0);
    chk("R8 takeInt", takeInt, 0);

    // R10 boundary and edge during acknowledge
    boundary(1'b1, 1'b1);
    intrLvl = 1'b0;
    nmiAsync = 1'b1; instrEnd = 1'b1; cyc(1); instrEnd = 1'b0;
    chk("R10 ack kept", ackReq, 1);
    chk("R10 no take", takeInt, 0);
    nmiAsync = 1'b0; cyc(4);
    chk("R10 ack still", ackReq, 1);
    ackCycle(8'h9C);
    chk("R10 vec from bus", vecType, 8'h9C);
    cyc(1);
    boundary(1'b0, 1'b0);
    chk("R10 pending taken", takeInt, 1);
    chk("R10 vec 2", vecType, 2);

    // R11 vector holds
    cyc(6);
    chk("R11 vec hold", vecType, 2);

    // R9 test synchronizer depth
    testIn = 1'b0; cyc(1);
    chk("R9 one edge", testHold, 1);
    cyc(1);
    chk("R9 two edges", testHold, 0);
    testIn = 1'b1; cyc(1);
    chk("R9 rise one edge", testHold, 0);
    cyc(1);
    chk("R9 rise two edges", testHold, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule